// File: doc/BRIEF.md
# Dual-Channel Phase-Count PWM Generator

This block drives two PWM outputs. For each channel the waveform is given as two phase lengths: a number of ticks spent high, then a number of ticks spent low. One period is therefore high-count plus low-count ticks, and the duty is the high-count alone. A tick is not the core clock. Each channel picks one of four enable-style tick inputs, divides the selected pulses by a programmable ratio, and passes the result through a gate. The output only advances on the ticks that come out of this chain.

All channel settings live in one shared control word: the output enables, the gate bits, the source selects and the divider ratios. Each channel also has its own count word holding its high and low counts. Software writes these words over a small synchronous write/read bus. Count values written while a channel is running are held back until the current low phase has ended, so a period already under way always finishes with the lengths it started with.

Top module: `duo_phase_pwm`

## Requirements
- R1: After reset both outputs are low and every register reads back as zero.
- R2: Address 0 is the control word, address 1 is channel A's count word and address 2 is channel B's count word, each with the high count in bits 31:16 and the low count in bits 15:0. Bits 3:2 and 31:24 of the control word read back as zero. Address 3 reads as zero and ignores writes. A read returns the value one clock after the address is presented.
- R3: A running channel whose source ticks on every clock produces high runs of exactly high-count cycles, followed by low runs of exactly low-count cycles.
- R4: The ratio field (channel A bits 14:8, channel B bits 22:16, 7 bits each) divides the selected source, so one tick occurs every ratio+1 source pulses.
- R5: The source select (channel A bits 5:4, channel B bits 7:6) picks tick input number 0 to 3 as the channel's source.
- R6: A channel advances only when its output enable (A bit 0, B bit 1) and its gate (A bit 15, B bit 23) are both set. Otherwise its output is low, and the next enable starts a new period with a full high phase.
- R7: A count word written during a period takes effect only at the end of that period's low phase.
- R8: A high count of 0 keeps the output low.
- R9: A low count of 0 with a high count below 0xFFFF keeps the output high.
- R10: A high count of 0xFFFF with a low count of 0 gives a 65536-tick period that is low for exactly one tick.
- R11: Both channels run independently at the same time, each with its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_src | input | 4 | Enable-style tick sources for the mux |
| pwm_out | output | 2 | PWM outputs, bit 0 is channel A |

## Verification
The bench builds the block with its default parameters: 16-bit phase counts, a 7-bit ratio and four tick sources. With these widths the 65536-tick corner at the top of the count range can be reached in about 65 thousand clocks when the ratio is 0 and the source is always asserted. The bench holds the four tick sources at different fixed rates (every clock, never, every second clock, every fourth clock). Every run length it measures then identifies which source and which ratio the block applied.

// File: rtl/duo_pwm_pkg.sv
package duo_pwm_pkg;
  localparam int CNT_W  = 16;
  localparam int DIV_W  = 7;
  localparam int N_SRC  = 4;
  localparam int SEL_W  = $clog2(N_SRC);
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 2;
  localparam int N_CH   = 2;

  // writable control bits: enables, selects, ratios, gates
  localparam logic [BUS_W-1:0] CTRL_MASK = 32'h00FF_FFF3;

  typedef struct packed {
    logic             oen;
    logic             gate;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] ratio;
  } chan_cfg_t;
endpackage

// File: rtl/duo_pwm_regs.sv
module duo_pwm_regs
  import duo_pwm_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int NCH = N_CH
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_we,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [BUS_W-1:0]             bus_wdata,
  output logic [BUS_W-1:0]             bus_rdata,
  output chan_cfg_t [NCH-1:0]          cfg,
  output logic [NCH-1:0][2*CW-1:0]     counts
);
  localparam int WW = 2 * CW;

  logic [BUS_W-1:0]          ctrl_q;
  logic [NCH-1:0][WW-1:0]    cnt_q;
  logic [BUS_W-1:0]          rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      cnt_q     <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_we && bus_addr == '0) ctrl_q <= bus_wdata & CTRL_MASK;
      for (int c = 0; c < NCH; c++) begin
        if (bus_we && bus_addr == ADDR_W'(c + 1)) cnt_q[c] <= bus_wdata[WW-1:0];
      end
      bus_rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == '0) rd_mux = ctrl_q;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(c + 1)) rd_mux = BUS_W'(cnt_q[c]);
    end
  end

  // per-channel field extraction from the shared control word
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      cfg[c].oen   = ctrl_q[c];
      cfg[c].sel   = ctrl_q[4 + SEL_W*c +: SEL_W];
      cfg[c].ratio = ctrl_q[8 + 8*c +: DIV_W];
      cfg[c].gate  = ctrl_q[15 + 8*c];
    end
  end

  assign counts = cnt_q;

  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == '0) |=> (ctrl_q == ($past(bus_wdata) & CTRL_MASK)));

  p_count_write_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(1)) |=> (cnt_q[0] == $past(bus_wdata[WW-1:0])));
endmodule

// File: rtl/duo_pwm_tick.sv
module duo_pwm_tick
  import duo_pwm_pkg::*;
#(
  parameter int NS = N_SRC,
  parameter int DW = DIV_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run,
  input  logic [$clog2(NS)-1:0]  sel,
  input  logic [DW-1:0]          ratio,
  input  logic [NS-1:0]          src,
  output logic                   tick
);
  logic          pick;
  logic [DW-1:0] div_q;

  assign pick = src[sel];

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (pick) begin
        if (div_q >= ratio) begin
          div_q <= '0;
          tick  <= 1'b1;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  p_gate_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> !tick);

  p_tick_needs_pick_r4: assert property (@(posedge clk) disable iff (rst)
    !pick |=> !tick);
endmodule

// File: rtl/duo_pwm_phase.sv
module duo_pwm_phase
  import duo_pwm_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            tick,
  input  logic [2*CW-1:0] cnt_word,
  output logic            pwm_o
);
  localparam int PW = CW + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic          primed;
  logic [PW-1:0] pos_q;
  logic [PW-1:0] last_q;
  logic [CW-1:0] hi_l;
  logic [CW-1:0] lo_l;
  logic [CW-1:0] new_hi;
  logic [CW-1:0] new_lo;
  logic [PW-1:0] new_last;
  logic [PW-1:0] sum;
  logic          at_end;

  assign new_hi = cnt_word[2*CW-1:CW];
  assign new_lo = cnt_word[CW-1:0];
  assign sum    = PW'(new_hi) + PW'(new_lo);
  assign at_end = !primed || (pos_q >= last_q);

  always_comb begin
    if (new_hi == CMAX && new_lo == '0) new_last = PW'(CMAX);
    else if (sum == '0)                 new_last = '0;
    else                                new_last = sum - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed <= 1'b0;
      pos_q  <= '0;
      last_q <= '0;
      hi_l   <= '0;
      lo_l   <= '0;
      pwm_o  <= 1'b0;
    end else if (!run) begin
      primed <= 1'b0;
      pos_q  <= '0;
      pwm_o  <= 1'b0;
    end else if (tick) begin
      if (at_end) begin
        primed <= 1'b1;
        hi_l   <= new_hi;
        lo_l   <= new_lo;
        last_q <= new_last;
        pos_q  <= '0;
        pwm_o  <= (new_hi != '0);
      end else begin
        pos_q  <= pos_q + 1'b1;
        pwm_o  <= ((pos_q + 1'b1) < PW'(hi_l));
      end
    end
  end

  p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pwm_o);

  p_zero_high_r8: assert property (@(posedge clk) disable iff (rst)
    pwm_o |-> (hi_l != '0));

  p_hold_counts_r7: assert property (@(posedge clk) disable iff (rst)
    (primed && !(tick && run && at_end)) |=> ($stable(hi_l) && $stable(lo_l)));

  p_pos_bound_r3: assert property (@(posedge clk) disable iff (rst)
    primed |-> (pos_q <= last_q));
endmodule

// File: rtl/duo_phase_pwm.sv
module duo_phase_pwm
  import duo_pwm_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int DW  = DIV_W,
  parameter int NS  = N_SRC,
  parameter int NCH = N_CH
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [NS-1:0]      tick_src,
  output logic [NCH-1:0]     pwm_out
);
  chan_cfg_t [NCH-1:0]       cfg;
  logic [NCH-1:0][2*CW-1:0]  counts;

  duo_pwm_regs #(.CW(CW), .NCH(NCH)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg       (cfg),
    .counts    (counts)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic run;
    logic tick;

    assign run = cfg[c].oen & cfg[c].gate;

    duo_pwm_tick #(.NS(NS), .DW(DW)) u_tick (
      .clk   (clk),
      .rst   (rst),
      .run   (run),
      .sel   (cfg[c].sel),
      .ratio (cfg[c].ratio),
      .src   (tick_src),
      .tick  (tick)
    );

    duo_pwm_phase #(.CW(CW)) u_phase (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .tick     (tick),
      .cnt_word (counts[c]),
      .pwm_o    (pwm_out[c])
    );
  end
endmodule

// File: tb/duo_phase_pwm_test.sv
module duo_phase_pwm_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_src = 4'b0001;
  logic [1:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  int phase_ctr = 0;

  always #2 clk = ~clk;

  duo_phase_pwm uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_src(tick_src), .pwm_out(pwm_out)
  );

  // sources: 0 always, 1 never, 2 every second clock, 3 every fourth clock
  initial begin
    forever begin
      @(negedge clk);
      phase_ctr = phase_ctr + 1;
      tick_src = {(phase_ctr % 4 == 0), (phase_ctr % 2 == 0), 1'b0, 1'b1};
    end
  end

  typedef struct packed {
    logic        ch;
    logic [15:0] hi;
    logic [15:0] lo;
    logic [6:0]  ratio;
    logic [1:0]  sel;
    logic [31:0] exp_h;
    logic [31:0] exp_l;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 16'd3,  16'd5, 7'd0, 2'd0, 32'd3,  32'd5},
    '{1'b0, 16'd7,  16'd2, 7'd2, 2'd0, 32'd21, 32'd6},
    '{1'b1, 16'd4,  16'd4, 7'd0, 2'd2, 32'd8,  32'd8},
    '{1'b1, 16'd2,  16'd6, 7'd1, 2'd3, 32'd16, 32'd48},
    '{1'b0, 16'd1,  16'd1, 7'd0, 2'd3, 32'd4,  32'd4},
    '{1'b1, 16'd10, 16'd3, 7'd0, 2'd0, 32'd10, 32'd3}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl_for(input logic ch, input logic [6:0] ratio,
                                           input logic [1:0] sel, input logic en, input logic gate);
    logic [31:0] v = '0;
    if (!ch) begin
      v[0] = en; v[5:4] = sel; v[14:8] = ratio; v[15] = gate;
    end else begin
      v[1] = en; v[7:6] = sel; v[22:16] = ratio; v[23] = gate;
    end
    return v;
  endfunction

  // returns at the negedge where the output has just taken the given level
  task automatic wait_level_edge(input int ch, input logic lvl, output bit ok);
    logic prev;
    ok = 1'b0;
    prev = pwm_out[ch];
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (prev != lvl && pwm_out[ch] == lvl) begin
        ok = 1'b1;
        break;
      end
      prev = pwm_out[ch];
    end
  endtask

  task automatic run_len(input int ch, input logic lvl, output int n);
    n = 1;
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (pwm_out[ch] != lvl) break;
      n++;
    end
  endtask

  task automatic measure(input int ch, output int h, output int l, output bit ok);
    wait_level_edge(ch, 1'b1, ok);
    run_len(ch, 1'b1, h);
    run_len(ch, 1'b0, l);
  endtask

  task automatic count_high(input int ch, input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) n++;
    end
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int h, l, n;
    bit ok;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(pwm_out == 2'b00, "R1 outputs low", pwm_out, 0);
    rd(2'd0, d); check(d == 0, "R1 control reads zero", d, 0);
    rd(2'd1, d); check(d == 0, "R1 count A reads zero", d, 0);
    rd(2'd2, d); check(d == 0, "R1 count B reads zero", d, 0);

    // R2: register map and readback masking
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check(d == 32'h00FF_FFF3, "R2 control mask", d, 32'h00FF_FFF3);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h1234_ABCD);
    rd(2'd1, d); check(d == 32'h1234_ABCD, "R2 count A readback", d, 32'h1234_ABCD);
    wr(2'd2, 32'h0BAD_F00D);
    rd(2'd2, d); check(d == 32'h0BAD_F00D, "R2 count B readback", d, 32'h0BAD_F00D);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d); check(d == 0, "R2 address 3 reads zero", d, 0);
    rd(2'd1, d); check(d == 32'h1234_ABCD, "R2 address 3 write ignored", d, 32'h1234_ABCD);

    // R3 R4 R5: vector table walk
    foreach (VECS[i]) begin
      wr(2'd0, 32'h0);
      wr(VECS[i].ch ? 2'd2 : 2'd1, {VECS[i].hi, VECS[i].lo});
      wr(2'd0, ctrl_for(VECS[i].ch, VECS[i].ratio, VECS[i].sel, 1'b1, 1'b1));
      measure(int'(VECS[i].ch), h, l, ok);
      check(ok, "R3 output toggles", ok, 1);
      check(h == int'(VECS[i].exp_h), "R3/R4/R5 high run", h, VECS[i].exp_h);
      check(l == int'(VECS[i].exp_l), "R3/R4/R5 low run", l, VECS[i].exp_l);
    end

    // R6: enable without gate, gate without enable
    wr(2'd0, 32'h0);
    wr(2'd1, {16'd3, 16'd3});
    wr(2'd0, ctrl_for(1'b0, 7'd0, 2'd0, 1'b1, 1'b0));
    count_high(0, 40, n); check(n == 0, "R6 gate clear holds low", n, 0);
    wr(2'd0, ctrl_for(1'b0, 7'd0, 2'd0, 1'b0, 1'b1));
    count_high(0, 40, n); check(n == 0, "R6 enable clear holds low", n, 0);

    // R6: re-enable mid period restarts with a full high phase
    wr(2'd1, {16'd9, 16'd4});
    wr(2'd0, ctrl_for(1'b0, 7'd0, 2'd0, 1'b1, 1'b1));
    wait_level_edge(0, 1'b1, ok);
    repeat (3) @(negedge clk);
    wr(2'd0, 32'h0);
    wr(2'd0, ctrl_for(1'b0, 7'd0, 2'd0, 1'b1, 1'b1));
    wait_level_edge(0, 1'b1, ok);
    run_len(0, 1'b1, h);
    check(h == 9, "R6 restart full high phase", h, 9);

    // R7: new counts written in low phase wait for the period end
    wr(2'd0, 32'h0);
    wr(2'd1, {16'd6, 16'd4});
    wr(2'd0, ctrl_for(1'b0, 7'd0, 2'd0, 1'b1, 1'b1));
    wait_level_edge(0, 1'b0, ok);
    bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = {16'd2, 16'd3};
    l = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      bus_we = 1'b0;
      if (pwm_out[0]) break;
      l++;
    end
    check(l == 4, "R7 current low phase kept", l, 4);
    run_len(0, 1'b1, h);
    run_len(0, 1'b0, l);
    check(h == 2, "R7 new high count next period", h, 2);
    check(l == 3, "R7 new low count next period", l, 3);

    // R8: zero high count
    wr(2'd0, 32'h0);
    wr(2'd1, {16'd0, 16'd5});
    wr(2'd0, ctrl_for(1'b0, 7'd0, 2'd0, 1'b1, 1'b1));
    count_high(0, 100, n); check(n == 0, "R8 zero high stays low", n, 0);

    // R9: zero low count
    wr(2'd0, 32'h0);
    wr(2'd1, {16'd5, 16'd0});
    wr(2'd0, ctrl_for(1'b0, 7'd0, 2'd0, 1'b1, 1'b1));
    repeat (10) @(negedge clk);
    count_high(0, 100, n); check(n == 100, "R9 zero low stays high", n, 100);

    // R10 and R11: B at maximum, A normal, both running
    wr(2'd0, 32'h0);
    wr(2'd1, {16'd3, 16'd5});
    wr(2'd2, {16'hFFFF, 16'd0});
    wr(2'd0, ctrl_for(1'b0, 7'd0, 2'd0, 1'b1, 1'b1) | ctrl_for(1'b1, 7'd0, 2'd0, 1'b1, 1'b1));
    repeat (10) @(negedge clk);
    count_high(1, 65536, n);
    check(n == 65535, "R10 one low tick per max period", 65536 - n, 1);
    measure(0, h, l, ok);
    check(h == 3 && l == 5, "R11 channel A unaffected by B", {h, l}, {32'd3, 32'd5});
    check(pwm_out[1] || n == 65535, "R11 channel B still running", pwm_out[1], 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule